// File: doc/BRIEF.md
# Channel-Gain Scan Queue Sequencer

This block holds a programmable list of scan entries and steps through it, one entry per conversion, so that the analog front end always sees the channel and gain for the next sample. Each entry is one byte. Its low three bits pick one of eight multiplexer inputs, and its upper nibble is a range code. There are nine range codes. Codes 0 to 3 are bipolar spans of ±5, ±2.5, ±1.25 and ±0.625 V. Codes 4 to 7 are unipolar spans of 10, 5, 2.5 and 1.25 V. Code 8 is ±10 V. Bit 6 of the byte is set for exactly the unipolar codes.

A host programs the list through a byte-wide register port with three registers. An index register points at an entry, an entry register writes the byte at that index, and a last-index register sets where the list wraps. While acquisition is enabled, every conversion strobe from the pacer advances the sequencer. After the last entry it returns to entry 0 and pulses a scan-done flag.

The block also checks the list combinationally against the front end's pairing rule. A list with more than one entry must have an even length, and the channel parity of each entry must match the parity of its index. A one-entry list is always accepted. A broken list raises an error flag, but conversions are still sequenced while the flag is up.

Top module: `scanq_sequencer`

## Requirements
- R1: After reset the index, the last-index register, every entry and scan_done are 0, so the outputs show channel 0, range code 0 and no list error.
- R2: A write with reg_sel=0 loads the index register from reg_wdata. A write with reg_sel=1 stores reg_wdata as the entry at that index.
- R3: The outputs decode the entry at the current sequencer index. cur_chan is bits [2:0], cur_range is bits [7:4] and cur_unipolar is bit 6. Bit 6 is 1 for range codes 4 to 7 and 0 for codes 0 to 3 and 8.
- R4: A write with reg_sel=2 sets the last index L, which gives a list length of L+1.
- R5: While acq_en is 1, each clock cycle with conv_strobe high and no index-register write advances cur_index by one when cur_index is below L.
- R6: A strobe taken at index L (or above it) returns cur_index to 0. scan_done is high for exactly the following cycle, unless that cycle also wraps.
- R7: While acq_en is 0, cur_index is 0 and strobes have no effect.
- R8: An index-register write returns cur_index to 0, and it takes priority over a strobe in the same cycle.
- R9: list_error is 1 when L is nonzero and the length L+1 is odd.
- R10: list_error is 1 when L is nonzero and some entry i ≤ L has channel bit 0 different from bit 0 of i. Entries above L are not checked.
- R11: With L=0, list_error is 0 whatever channel entry 0 holds.
- R12: Strobes still advance and wrap the index while list_error is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 entry, 2 last index |
| reg_wdata | input | 8 | Register write data |
| acq_en | input | 1 | Acquisition enable |
| conv_strobe | input | 1 | Conversion strobe from the pacer |
| cur_index | output | IW | Current sequencer index |
| cur_chan | output | 3 | Channel of the current entry |
| cur_range | output | 4 | Range code of the current entry |
| cur_unipolar | output | 1 | Unipolar flag of the current entry |
| scan_done | output | 1 | One-cycle pulse after a wrap to entry 0 |
| list_error | output | 1 | Combinational list-rule violation flag |

## Verification
Register writes and strobes take effect at the next rising edge. cur_index, the entry decode and scan_done are therefore valid in the cycle that follows, and list_error settles combinationally from the updated registers in that same cycle. The bench drives every stimulus at a falling edge, holds it across one rising edge and samples at the next falling edge, so each result is checked exactly one cycle after its cause. It also checks that scan_done is low again one cycle later. The expected index and the error flag come from a counter model and from parity arithmetic in the bench.

// File: rtl/scanq_pkg.sv
package scanq_pkg;
  typedef logic [7:0] entry_t;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_ENTRY = 2'd1,
    SEL_LAST  = 2'd2
  } reg_sel_e;

  function automatic logic [2:0] f_chan(entry_t e);
    return e[2:0];
  endfunction

  function automatic logic [3:0] f_range(entry_t e);
    return e[7:4];
  endfunction

  function automatic logic f_unipolar(entry_t e);
    return e[6];
  endfunction

  // parity mismatch between an entry's channel and its position
  function automatic logic f_parity_bad(entry_t e, logic idx_lsb);
    return e[0] ^ idx_lsb;
  endfunction
endpackage

// File: rtl/scanq_regs.sv
module scanq_regs
  import scanq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  output logic          addr_wr,
  output logic [IW-1:0] last_idx,
  output entry_t        mem [DEPTH]
);
  logic [IW-1:0] qaddr;
  logic          entry_wr, last_wr;

  assign addr_wr  = wr_en && (wr_sel == SEL_INDEX);
  assign entry_wr = wr_en && (wr_sel == SEL_ENTRY);
  assign last_wr  = wr_en && (wr_sel == SEL_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qaddr    <= '0;
      last_idx <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (addr_wr)  qaddr    <= wr_data[IW-1:0];
      if (last_wr)  last_idx <= wr_data[IW-1:0];
      if (entry_wr) mem[qaddr] <= wr_data;
    end
  end

  // R2: entry byte lands at the index held before the write
  p_entry_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_wr |=> mem[$past(qaddr)] == $past(wr_data));

  // R4: last index register follows its write
  p_last_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> last_idx == $past(wr_data[IW-1:0]));
endmodule

// File: rtl/scanq_seq.sv
module scanq_seq #(
  parameter int DEPTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_en,
  input  logic          conv_strobe,
  input  logic          addr_wr,
  input  logic [IW-1:0] last_idx,
  output logic [IW-1:0] idx,
  output logic          scan_done,
  output logic          step_evt,
  output logic          wrap_evt
);
  assign step_evt = acq_en && conv_strobe && !addr_wr;
  assign wrap_evt = step_evt && (idx >= last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= wrap_evt;
      if (!acq_en || addr_wr) idx <= '0;
      else if (wrap_evt)      idx <= '0;
      else if (step_evt)      idx <= idx + 1'b1;
    end
  end

  // R5: a strobe below the last index advances by one
  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && idx < last_idx) |=> idx == $past(idx) + 1'b1);

  // R6: a wrap returns to entry 0 with the done pulse
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (idx == '0) && scan_done);

  // R7: disabled acquisition parks the index at 0
  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |=> idx == '0);

  // R8: index register write restarts the list
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> idx == '0);

  // R6: done only follows a wrap
  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> idx == '0);
endmodule

// File: rtl/scanq_check.sv
module scanq_check
  import scanq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  entry_t        mem [DEPTH],
  input  logic [IW-1:0] last_idx,
  output logic          odd_len,
  output logic          parity_bad,
  output logic          list_error
);
  logic multi;

  assign multi   = (last_idx != '0);
  assign odd_len = ~last_idx[0];

  always_comb begin
    parity_bad = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((IW'(i) <= last_idx) && f_parity_bad(mem[i], 1'(i)))
        parity_bad = 1'b1;
    end
  end

  assign list_error = multi && (odd_len || parity_bad);

  // R11: one-entry list never flagged
  p_single_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (last_idx == '0) |-> !list_error);

  // R10: a mismatch at entry 0 or 1 of a multi-entry list is flagged
  p_head_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && (mem[0][0] || !mem[1][0])) |-> list_error);
endmodule

// File: rtl/scanq_sequencer.sv
module scanq_sequencer
  import scanq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          acq_en,
  input  logic          conv_strobe,
  output logic [IW-1:0] cur_index,
  output logic [2:0]    cur_chan,
  output logic [3:0]    cur_range,
  output logic          cur_unipolar,
  output logic          scan_done,
  output logic          list_error
);
  entry_t        mem [DEPTH];
  entry_t        cur_entry;
  logic          addr_wr;
  logic [IW-1:0] last_idx;
  logic          step_evt, wrap_evt, odd_len, parity_bad;

  scanq_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .addr_wr(addr_wr), .last_idx(last_idx), .mem(mem)
  );

  scanq_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .conv_strobe(conv_strobe),
    .addr_wr(addr_wr), .last_idx(last_idx), .idx(cur_index),
    .scan_done(scan_done), .step_evt(step_evt), .wrap_evt(wrap_evt)
  );

  scanq_check #(.DEPTH(DEPTH)) u_check (
    .clk(clk), .rst_n(rst_n), .mem(mem), .last_idx(last_idx),
    .odd_len(odd_len), .parity_bad(parity_bad), .list_error(list_error)
  );

  assign cur_entry    = mem[cur_index];
  assign cur_chan     = f_chan(cur_entry);
  assign cur_range    = f_range(cur_entry);
  assign cur_unipolar = f_unipolar(cur_entry);

  // R12: a flagged list keeps sequencing
  p_run_on_error_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (list_error && step_evt && !wrap_evt) |=> cur_index == $past(cur_index) + 1'b1);

  // R9: odd multi-entry length raises the flag
  p_odd_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_len && last_idx != '0) |-> list_error);
endmodule

// File: tb/scanq_sequencer_bench.sv
module scanq_sequencer_bench;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic acq_en = 1'b0;
  logic conv_strobe = 1'b0;
  logic [IW-1:0] cur_index;
  logic [2:0] cur_chan;
  logic [3:0] cur_range;
  logic cur_unipolar, scan_done, list_error;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  scanq_sequencer u_scanq_sequencer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .acq_en(acq_en), .conv_strobe(conv_strobe),
    .cur_index(cur_index), .cur_chan(cur_chan), .cur_range(cur_range),
    .cur_unipolar(cur_unipolar), .scan_done(scan_done), .list_error(list_error)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    conv_strobe = 1'b1;
    @(negedge clk);
    conv_strobe = 1'b0;
  endtask

  function automatic int rng(int i); return i % 9; endfunction
  function automatic logic [7:0] good_entry(int i);
    return 8'((rng(i) << 4) | (i % 8));
  endfunction

  task automatic load_list(input int len);
    for (int i = 0; i < len; i++) begin
      wr(2'd0, 8'(i));
      wr(2'd1, good_entry(i));
    end
    wr(2'd2, 8'(len - 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_idx;
    int last;
    bit wrapped;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 index", cur_index, 0);
    chk("R1 done", scan_done, 0);
    chk("R1 error", list_error, 0);
    chk("R1 chan", cur_chan, 0);
    chk("R1 range", cur_range, 0);

    // R2 R3 R4 R5 R6: program eight entries and run past the wrap twice
    load_list(8);
    last = 7;
    chk("R9 even length ok", list_error, 0);
    acq_en = 1'b1;
    exp_idx = 0;
    @(negedge clk);
    chk("R3 entry0 chan", cur_chan, 0);
    for (int n = 0; n < 20; n++) begin
      wrapped = (exp_idx == last);
      exp_idx = wrapped ? 0 : exp_idx + 1;
      strobe();
      chk("R5 index", cur_index, exp_idx);
      chk("R3 chan", cur_chan, exp_idx % 8);
      chk("R3 range", cur_range, rng(exp_idx));
      chk("R3 unipolar", cur_unipolar, (rng(exp_idx) >= 4 && rng(exp_idx) <= 7) ? 1 : 0);
      chk("R6 done", scan_done, wrapped ? 1 : 0);
    end
    // drive to the wrap then watch the pulse drop
    while (exp_idx != last) begin strobe(); exp_idx++; end
    strobe();
    chk("R6 wrap index", cur_index, 0);
    chk("R6 pulse high", scan_done, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", scan_done, 0);

    // R7 disable parks and ignores strobes
    strobe(); strobe(); strobe();
    chk("R5 before disable", cur_index, 3);
    acq_en = 1'b0;
    @(negedge clk);
    chk("R7 parked", cur_index, 0);
    strobe();
    chk("R7 strobe ignored", cur_index, 0);
    acq_en = 1'b1;

    // R8 index write wins over a strobe
    strobe(); strobe();
    chk("R5 at 2", cur_index, 2);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'd5; conv_strobe = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; conv_strobe = 1'b0;
    chk("R8 restart", cur_index, 0);

    // R9 R11 length sweep over a parity-correct list
    for (int len = 1; len <= 8; len++) begin
      wr(2'd2, 8'(len - 1));
      chk(len == 1 ? "R11 single" : "R9 length", list_error,
          (len > 1 && (len % 2) == 1) ? 1 : 0);
    end

    // R10 every bad position inside each even length, and one just past it
    for (int len = 2; len <= 8; len += 2) begin
      wr(2'd2, 8'(len - 1));
      for (int p = 0; p < len + 1; p++) begin
        wr(2'd0, 8'(p));
        wr(2'd1, good_entry(p) ^ 8'h01);
        chk(p < len ? "R10 bad parity" : "R10 outside list", list_error, p < len ? 1 : 0);
        wr(2'd0, 8'(p));
        wr(2'd1, good_entry(p));
      end
    end

    // R11 single odd channel at entry 0
    wr(2'd0, 8'd0);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'd0);
    chk("R11 single odd chan", list_error, 0);

    // R12 a flagged list keeps running (length 3)
    wr(2'd1, good_entry(0));
    wr(2'd2, 8'd2);
    chk("R12 flagged", list_error, 1);
    wr(2'd0, 8'd0);
    strobe();
    chk("R12 advance", cur_index, 1);
    strobe(); strobe();
    chk("R12 wrap", cur_index, 0);
    chk("R12 done", scan_done, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule